// File: doc/BRIEF.md
# Word-Organized Memory Read Port

This block is the bus-side read interface of a 768-byte data store that holds its contents as 16-bit words. It claims a fixed address window, returns single bytes and whole words, and stitches a word that starts on an odd byte address from two stored words. Bytes are ordered big-endian: the byte at the lower address sits in the upper half of a word.

A one-byte control register in a separate small register window carries a visibility bit. While that bit is clear the window goes silent for reads, so a lower-priority resource decoded at the same addresses can answer. The control register answers whatever the bit holds. A busy input from the write/erase machinery stalls reads of the store until it drops.

Requests use a valid/ready handshake. The requester holds the request steady until ready is seen high. Byte and even-address word reads finish in the cycle they are presented. An odd-address word read holds ready low for one extra cycle. The store is a register model that loads a computed image at reset.

Top module: `wmr_read_port`

## Requirements
- R1: The store answers addresses 0x0D00 to 0x0FFF (768 bytes). A read or write that falls in neither this window nor the register window gives rsp_hit=0, rsp_data=0, rsp_err=0 and req_ready=1 in the same cycle.
- R2: A byte read (req_size=0) of the visible store completes in its first cycle with rsp_hit=1 and rsp_data={8'h00, byte}.
- R3: A word read (req_size=1) at an even address A completes in its first cycle with rsp_data={byte A, byte A+1}.
- R4: A word read at an odd address A holds req_ready low in its first cycle. It completes in the second cycle with rsp_data={byte A, byte A+1}, where byte A+1 comes from the next stored word. Dropping req_valid in between abandons the access.
- R5: A word read at 0x0FFF completes in one cycle with rsp_err=1 and rsp_data=16'hFFFF.
- R6: Bit 0 of the control register makes the store visible. While it is 0, reads of the window give rsp_hit=0, rsp_data=0 and req_ready=1.
- R7: The control register is one byte at 0x00F0 inside a 4-byte register window at 0x00F0 to 0x00F3. It resets to 0x01 and responds whatever bit 0 holds. A byte write loads req_wdata[7:0]. A word write at 0x00F0 loads req_wdata[15:8]. A byte read gives {8'h00, reg}. A word read at 0x00F0 gives {reg, 8'h00}. Bytes 0x00F1 to 0x00F3 read 0 and ignore writes.
- R8: While pgm_busy=1, a read of the visible store keeps req_ready low and keeps its progress. Register accesses are not affected.
- R9: After reset, store byte at window offset k holds (k*37 + 0x5A) mod 256. Writes into the window are ignored: rsp_hit=0, req_ready=1, and the contents are unchanged.
- R10: While req_valid=0, req_ready, rsp_hit and rsp_err are 0 and rsp_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| pgm_busy | input | 1 | Write/erase machinery busy; stalls store reads |
| req_ready | output | 1 | Request completes this cycle |
| rsp_hit | output | 1 | This block claims the access |
| rsp_err | output | 1 | Odd word read at the last byte of the window |
| rsp_data | output | 16 | Read data, valid when req_ready is high |

## Verification
The bench builds the block with its default parameters: window base 0x0D00, 768 bytes, control register at 0x00F0 and image multiplier 37 with offset 0x5A. These defaults put both window edges and the neighbouring out-of-window addresses within reach. They also reach the odd read at the last byte and the clash of busy with the second half of a split read. The image gives every pair of adjacent bytes different values, so a swapped half or a byte taken from the wrong word shows up in the data.

// File: rtl/wmr_pkg.sv
// Shared types and the reset-image functions of the word-organized read port.
// Assumes an 8-bit byte and 16-bit words with the lower address in the upper half.
package wmr_pkg;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    // Image byte at window offset k: (k*mul + add) mod 256.
    function automatic logic [7:0] image_byte(int unsigned k, int unsigned mul, int unsigned add);
        int unsigned t;
        t = k * mul + add;
        return t[7:0];
    endfunction

    // Image word w packs byte 2w (upper half) and byte 2w+1 (lower half).
    function automatic logic [15:0] image_word(int unsigned w, int unsigned mul, int unsigned add);
        return {image_byte(2 * w, mul, add), image_byte(2 * w + 1, mul, add)};
    endfunction

endpackage

// File: rtl/wmr_decode.sv
// Address decoder: flags the store window and the register window and gives
// the byte offset into each. Assumes the two windows do not overlap.
module wmr_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BASE  = 'h0D00,
    parameter int unsigned WIN_BYTES = 768,
    parameter int unsigned REG_BASE  = 'h00F0,
    parameter int unsigned REG_BYTES = 4,
    localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
    localparam int unsigned RB_W     = $clog2(REG_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [OFF_W-1:0]  win_off,
    output logic              in_reg,
    output logic [RB_W-1:0]   reg_off
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] REG_LO = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] REG_HI = ADDR_W'(REG_BASE + REG_BYTES - 1);

    logic [ADDR_W-1:0] win_diff;
    logic [ADDR_W-1:0] reg_diff;

    // Range compares and offset subtraction for both windows.
    always_comb begin
        win_diff = addr - WIN_LO;
        reg_diff = addr - REG_LO;
        in_win   = (addr >= WIN_LO) && (addr <= WIN_HI);
        in_reg   = (addr >= REG_LO) && (addr <= REG_HI);
        win_off  = win_diff[OFF_W-1:0];
        reg_off  = reg_diff[RB_W-1:0];
    end

endmodule

// File: rtl/wmr_array.sv
// Register model of the word store: WORDS words of 16 bits with one
// combinational read port. Loads a computed image on reset and has no write
// path. Indexes past the last word read as all ones.
module wmr_array #(
    parameter int unsigned WORDS   = 384,
    parameter int unsigned PAT_MUL = 37,
    parameter int unsigned PAT_ADD = 'h5A,
    localparam int unsigned IDX_W  = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_word
);
    logic [15:0] mem_q [WORDS];

    // Load the reset image; contents hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= wmr_pkg::image_word(w, PAT_MUL, PAT_ADD);
            end
        end
    end

    generate
        if (WORDS == (1 << IDX_W)) begin : g_full
            // Every index is a real word: plain read.
            always_comb rd_word = mem_q[rd_idx];
        end else begin : g_bounded
            localparam logic [IDX_W:0] WORDS_L = (IDX_W + 1)'(WORDS);
            // Guard the unused top of the index range.
            always_comb rd_word = ({1'b0, rd_idx} < WORDS_L) ? mem_q[rd_idx] : 16'hFFFF;
        end
    endgenerate

endmodule

// File: rtl/wmr_ctrl.sv
// Control register: one byte, bit 0 makes the store visible. Also formats
// reads of the register window. Assumes the register sits at window offset 0.
module wmr_ctrl #(
    parameter int unsigned REG_BYTES = 4,
    localparam int unsigned RB_W     = $clog2(REG_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_byte,
    input  logic [RB_W-1:0] rd_off,
    input  logic            rd_word,
    output logic            vis_en,
    output logic [15:0]     rd_data
);
    logic [7:0]  ctrl_q;
    logic [RB_W:0] off0;
    logic [RB_W:0] off1;

    // Register update; reset leaves the store visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 8'h01;
        end else if (wr_en) begin
            ctrl_q <= wr_byte;
        end
    end

    // Byte at a register-window offset: only offset 0 holds data.
    function automatic logic [7:0] reg_byte(logic [RB_W:0] o, logic [7:0] r);
        return (o == '0) ? r : 8'h00;
    endfunction

    // Read formatting for byte and word reads, big-endian.
    always_comb begin
        off0    = {1'b0, rd_off};
        off1    = off0 + (RB_W + 1)'(1);
        vis_en  = ctrl_q[0];
        rd_data = rd_word ? {reg_byte(off0, ctrl_q), reg_byte(off1, ctrl_q)}
                          : {8'h00, reg_byte(off0, ctrl_q)};
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q)); // R7

endmodule

// File: rtl/wmr_seq.sv
// Read sequencer for the store: serves byte and even word reads in one cycle,
// splits odd word reads into two fetches and flags the odd read at the
// last byte. Assumes the requester holds the request while ready is low.
module wmr_seq #(
    parameter int unsigned WIN_BYTES = 768,
    localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
    localparam int unsigned IDX_W    = OFF_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             size_word,
    input  logic [OFF_W-1:0] off,
    input  logic             busy,
    input  logic [15:0]      fetch_word,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             ready,
    output logic             err,
    output logic [15:0]      data
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WIN_BYTES - 1);

    logic       phase_q, phase_d;
    logic [7:0] hold_q, hold_d;
    logic       odd_word;
    logic [IDX_W-1:0] base_idx;

    // Fetch address: first word, or the next word in the second phase.
    always_comb begin
        odd_word  = size_word && off[0];
        base_idx  = off[OFF_W-1:1];
        fetch_idx = phase_q ? base_idx + IDX_W'(1) : base_idx;
    end

    // Per-cycle response and next-phase choice.
    always_comb begin
        ready   = 1'b0;
        err     = 1'b0;
        data    = 16'h0000;
        phase_d = 1'b0;
        hold_d  = hold_q;
        if (sel) begin
            if (busy) begin
                phase_d = phase_q;
            end else if (odd_word && (off == LAST_OFF)) begin
                ready = 1'b1;
                err   = 1'b1;
                data  = 16'hFFFF;
            end else if (odd_word && !phase_q) begin
                phase_d = 1'b1;
                hold_d  = fetch_word[7:0];
            end else if (odd_word) begin
                ready = 1'b1;
                data  = {hold_q, fetch_word[15:8]};
            end else if (size_word) begin
                ready = 1'b1;
                data  = fetch_word;
            end else begin
                ready = 1'b1;
                data  = {8'h00, off[0] ? fetch_word[7:0] : fetch_word[15:8]};
            end
        end
    end

    // Phase and held-byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            hold_q  <= 8'h00;
        end else begin
            phase_q <= phase_d;
            hold_q  <= hold_d;
        end
    end

    AST_SPLIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q) |-> $past(sel) && !$past(ready)); // R4
    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q && sel && !busy) |-> ready); // R4

endmodule

// File: rtl/wmr_read_port.sv
// Top of the word-organized read port: decodes the store and register
// windows, applies the visibility bit and busy stall, and merges responses.
// Assumes the requester holds a request steady until req_ready is high.
module wmr_read_port #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BASE  = 'h0D00,
    parameter int unsigned WIN_BYTES = 768,
    parameter int unsigned REG_BASE  = 'h00F0,
    parameter int unsigned REG_BYTES = 4,
    parameter int unsigned PAT_MUL   = 37,
    parameter int unsigned PAT_ADD   = 'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              pgm_busy,
    output logic              req_ready,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [15:0]       rsp_data
);
    localparam int unsigned OFF_W = $clog2(WIN_BYTES);
    localparam int unsigned IDX_W = OFF_W - 1;
    localparam int unsigned WORDS = WIN_BYTES / 2;
    localparam int unsigned RB_W  = $clog2(REG_BYTES);

    logic             in_win, in_reg;
    logic [OFF_W-1:0] win_off;
    logic [RB_W-1:0]  reg_off;
    logic             vis_en;
    logic             arr_sel, reg_sel, reg_wr;
    logic [7:0]       reg_wbyte;
    logic [15:0]      reg_rdata;
    logic [IDX_W-1:0] fetch_idx;
    logic [15:0]      fetch_word;
    logic             seq_ready, seq_err;
    logic [15:0]      seq_data;

    wmr_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .REG_BASE(REG_BASE), .REG_BYTES(REG_BYTES)
    ) u_decode (
        .addr(req_addr), .in_win(in_win), .win_off(win_off),
        .in_reg(in_reg), .reg_off(reg_off)
    );

    // Claim and register-write qualification.
    always_comb begin
        arr_sel   = req_valid && !req_write && in_win && vis_en;
        reg_sel   = req_valid && in_reg;
        reg_wr    = reg_sel && req_write && (reg_off == '0);
        reg_wbyte = (req_size == wmr_pkg::SZ_WORD) ? req_wdata[15:8] : req_wdata[7:0];
    end

    wmr_ctrl #(.REG_BYTES(REG_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_byte(reg_wbyte),
        .rd_off(reg_off), .rd_word(req_size), .vis_en(vis_en), .rd_data(reg_rdata)
    );

    wmr_array #(.WORDS(WORDS), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_idx(fetch_idx), .rd_word(fetch_word)
    );

    wmr_seq #(.WIN_BYTES(WIN_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .sel(arr_sel), .size_word(req_size),
        .off(win_off), .busy(pgm_busy), .fetch_word(fetch_word),
        .fetch_idx(fetch_idx), .ready(seq_ready), .err(seq_err), .data(seq_data)
    );

    // Response merge: store, then register window, else silent completion.
    always_comb begin
        req_ready = arr_sel ? seq_ready : req_valid;
        rsp_hit   = arr_sel || reg_sel;
        rsp_err   = arr_sel && seq_err;
        if (arr_sel) begin
            rsp_data = seq_data;
        end else if (reg_sel && !req_write) begin
            rsp_data = reg_rdata;
        end else begin
            rsp_data = 16'h0000;
        end
    end

    AST_ERR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> req_ready && (rsp_data == 16'hFFFF)); // R5
    AST_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && in_win && !vis_en) |-> !rsp_hit && (rsp_data == 16'h0000)); // R6
    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_sel && pgm_busy) |-> !req_ready); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_ready && !rsp_hit && !rsp_err); // R10

endmodule

// File: tb/tb_wmr_read_port.sv
`timescale 1ns/1ps
module tb_wmr_read_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0, pgm_busy = 1'b0;
    logic [15:0] req_addr = 16'h0, req_wdata = 16'h0;
    logic        req_ready, rsp_hit, rsp_err;
    logic [15:0] rsp_data;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    // Behavioural model state.
    int m_ctrl = 1;
    bit m_phase = 1'b0;
    bit exp_rdy, exp_hit, exp_err;
    int exp_dat;

    always #2.5 clk = ~clk;

    wmr_read_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .pgm_busy(pgm_busy), .req_ready(req_ready), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    function automatic int img(int k);
        return (k * 37 + 'h5A) % 256;
    endfunction

    function automatic int regb(int o);
        return (o == 0) ? m_ctrl : 0;
    endfunction

    // One cycle: drive, predict, compare, advance the model.
    task automatic step(bit v, bit w, bit sz, int a, int wd, bit busy);
        string tag;
        bit in_win, in_reg, arr, odd;
        int off, nphase, nctrl;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz;
        req_addr = 16'(a); req_wdata = 16'(wd); pgm_busy = busy;
        #1;
        in_win = (a >= 'h0D00) && (a <= 'h0FFF);
        in_reg = (a >= 'h00F0) && (a <= 'h00F3);
        off = a - 'h0D00;
        odd = sz && (a % 2 == 1);
        arr = v && !w && in_win && (m_ctrl % 2 == 1) && rst_n;
        exp_rdy = 0; exp_hit = 0; exp_err = 0; exp_dat = 0;
        nphase = 0; nctrl = m_ctrl;
        if (!v) begin
            tag = "R10";
        end else if (arr) begin
            exp_hit = 1;
            if (busy) begin
                tag = "R8"; nphase = m_phase;
            end else if (odd && off == 767) begin
                tag = "R5"; exp_rdy = 1; exp_err = 1; exp_dat = 'hFFFF;
            end else if (odd && !m_phase) begin
                tag = "R4"; nphase = 1;
            end else if (odd) begin
                tag = "R4"; exp_rdy = 1; exp_dat = img(off) * 256 + img(off + 1);
            end else if (sz) begin
                tag = "R3"; exp_rdy = 1; exp_dat = img(off) * 256 + img(off + 1);
            end else begin
                tag = "R2"; exp_rdy = 1; exp_dat = img(off);
            end
        end else if (in_reg) begin
            tag = "R7"; exp_rdy = 1; exp_hit = 1;
            if (w) begin
                if (a == 'h00F0) nctrl = sz ? (wd / 256) % 256 : wd % 256;
            end else begin
                exp_dat = sz ? regb(a - 'h00F0) * 256 + regb(a - 'h00F0 + 1) : regb(a - 'h00F0);
            end
        end else if (in_win && w) begin
            tag = "R9"; exp_rdy = 1;
        end else if (in_win) begin
            tag = "R6"; exp_rdy = 1;
        end else begin
            tag = "R1"; exp_rdy = 1;
        end
        vectors++;
        if (req_ready !== exp_rdy || rsp_hit !== exp_hit || rsp_err !== exp_err
            || rsp_data !== 16'(exp_dat)) begin
            misses++;
            $display("FAIL %s addr=%h: ready/hit/err/data = %b/%b/%b/%h, expected %b/%b/%b/%h",
                     tag, a[15:0], req_ready, rsp_hit, rsp_err, rsp_data,
                     exp_rdy, exp_hit, exp_err, exp_dat[15:0]);
        end
        if (rst_n) begin
            m_phase = nphase[0];
            m_ctrl  = nctrl;
        end
    endtask

    // A read held until it completes.
    task automatic rd(bit sz, int a, int busy_n);
        for (int n = 0; n < 12; n++) begin
            step(1, 0, sz, a, 0, n < busy_n);
            if (exp_rdy) break;
        end
    endtask

    task automatic wr(bit sz, int a, int wd);
        step(1, 1, sz, a, wd, 0);
    endtask

    initial begin
        // R10 during and after reset.
        repeat (3) step(0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 'h0D00, 0, 0);
        rd(0, 'h00F0, 0);                         // R7 reset value
        rd(0, 'h0D00, 0); rd(0, 'h0D01, 0);       // R2, R9 image
        rd(0, 'h0FFF, 0); rd(0, 'h0E55, 0);       // R2
        rd(1, 'h0D00, 0); rd(1, 'h0FFE, 0);       // R3
        rd(1, 'h0D01, 0); rd(1, 'h0EFF, 0); rd(1, 'h0FFD, 0); // R4
        rd(1, 'h0FFF, 0);                         // R5
        rd(1, 'h0D03, 2);                         // R8 stall before split
        step(1, 0, 1, 'h0E21, 0, 0);              // R4 first half
        step(1, 0, 1, 'h0E21, 0, 1);              // R8 stall mid split
        step(1, 0, 1, 'h0E21, 0, 1);
        step(1, 0, 1, 'h0E21, 0, 0);
        step(1, 0, 1, 'h0D05, 0, 0);              // R4 abandon
        step(0, 0, 0, 0, 0, 0);
        rd(1, 'h0D06, 0);
        rd(0, 'h0CFF, 0); rd(1, 'h1000, 0);       // R1 edges
        wr(1, 'h0D00, 'h1234); rd(1, 'h0D00, 0);  // R9 write ignored
        wr(0, 'h00F0, 'h00FE);                    // R6 hide
        rd(0, 'h0D00, 0); rd(1, 'h0D01, 0);
        rd(0, 'h00F0, 0); rd(1, 'h00F0, 0);       // R7 still reachable
        rd(0, 'h00F0, 3);                         // R8 busy ignores register
        wr(0, 'h00F1, 'h00FF); rd(1, 'h00F0, 0); rd(1, 'h00F3, 0);
        wr(1, 'h00F0, 'h0300);                    // R7 word write
        rd(1, 'h00F0, 0); rd(1, 'h0D01, 0);
        for (int i = 0; i < 2000; i++) begin
            int pick, a;
            bit sz;
            pick = int'($urandom_range(0, 9));
            sz = 1'($urandom_range(0, 1));
            case (pick)
                0: a = 'h00F0 + int'($urandom_range(0, 3));
                1: a = 'h0FF8 + int'($urandom_range(0, 7));
                2: a = 'h0CF8 + int'($urandom_range(0, 15));
                3: a = int'($urandom_range(0, 65535));
                default: a = 'h0D00 + int'($urandom_range(0, 767));
            endcase
            if ($urandom_range(0, 9) == 0) begin
                wr(sz, a, (a == 'h00F0 && $urandom_range(0, 3) == 0) ? 0 : 'h0101);
            end else begin
                rd(sz, a, int'($urandom_range(0, 3)) == 0 ? int'($urandom_range(1, 3)) : 0);
            end
            if ($urandom_range(0, 3) == 0) step(0, 0, 0, 0, 0, 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule